// File: doc/BRIEF.md
# Dual-Access Complex Sample RAM

This block is the working store of a radix-2 decimation-in-time FFT engine. It holds N = 2^LOG2N complex samples. The real and imaginary parts of each sample are separate 32-bit words, kept in two parallel arrays that share one address. The same array holds the input samples and, once the transform has run in place, the results. Every access is synchronous to the one clock that the whole engine uses.

A two-bit mode input chooses who owns the memory. In load mode a host pushes samples over a valid/ready stream. The k-th accepted sample goes to the address whose LOG2N bits are those of k in reverse order, so the butterflies find their operands in decimation-in-time order. In compute mode an external controller drives two read addresses and two write ports. Every cycle it can fetch two complex operands and retire two complex results. The block generates no stage addresses and does no arithmetic. In unload mode the block streams the contents out in natural address order over a valid/ready stream.

Back-pressure rules: `ld_ready` is high only in load mode while fewer than N samples have been taken, and a sample moves on any rising edge where `ld_valid` and `ld_ready` are both high. `ul_valid` is raised by the block. While `ul_ready` is low, `ul_valid` and the data stay unchanged, and a word counts as delivered on the edge where both are high.

Top module: `cplx_sample_ram`

## Requirements
- R1: Mode codes are 2'b00 load, 2'b01 compute, 2'b10 unload and 2'b11 idle. `ld_ready` is high only in load mode, and only while fewer than N samples have been accepted since the mode last became load.
- R2: The k-th sample accepted in load mode, counting from 0, is stored at the address formed by reversing the LOG2N bits of k. The count restarts at 0 whenever the mode is not load.
- R3: In compute mode, the words at `bf_a_raddr` and `bf_b_raddr` appear on the A and B read outputs one clock edge after the addresses are sampled. Both reads happen in the same cycle.
- R4: In compute mode, both write ports store their real and imaginary words on the same edge, and later reads return the new contents.
- R5: When both write ports are enabled for the same address on one edge, the data from port A is what the address keeps.
- R6: A read of an address that is being written on the same edge returns the contents from before that write.
- R7: Host load inputs change nothing outside load mode. The butterfly write ports change nothing outside compute mode.
- R8: In unload mode, words leave in address order 0 to N-1 over the valid/ready stream. Valid and data are held while ready is low. The sequence restarts at address 0 each time unload mode is entered.
- R9: `ul_valid` is low in every cycle that follows a cycle spent outside unload mode. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the whole engine |
| rst_n | input | 1 | Active-low reset of the sequencing state |
| mode | input | 2 | Access mode: 00 load, 01 compute, 10 unload, 11 idle |
| ld_valid | input | 1 | Host sample valid |
| ld_ready | output | 1 | Block can take a host sample |
| ld_re | input | 32 | Host sample real word |
| ld_im | input | 32 | Host sample imaginary word |
| bf_a_raddr | input | LOG2N | Butterfly read address, port A |
| bf_b_raddr | input | LOG2N | Butterfly read address, port B |
| bf_a_re | output | 32 | Port A read data, real |
| bf_a_im | output | 32 | Port A read data, imaginary |
| bf_b_re | output | 32 | Port B read data, real |
| bf_b_im | output | 32 | Port B read data, imaginary |
| bf_a_we | input | 1 | Port A write enable |
| bf_a_waddr | input | LOG2N | Port A write address |
| bf_a_wre | input | 32 | Port A write data, real |
| bf_a_wim | input | 32 | Port A write data, imaginary |
| bf_b_we | input | 1 | Port B write enable |
| bf_b_waddr | input | LOG2N | Port B write address |
| bf_b_wre | input | 32 | Port B write data, real |
| bf_b_wim | input | 32 | Port B write data, imaginary |
| ul_valid | output | 1 | Unload word valid |
| ul_ready | input | 1 | Host can take an unload word |
| ul_re | output | 32 | Unload word, real |
| ul_im | output | 32 | Unload word, imaginary |

## Verification
The bench loads samples with gaps in `ld_valid`. It then reads address pairs one half-array apart. A design that stored samples in natural order, or reversed the wrong number of bits, returns the wrong operands here. It provokes a same-address double write, where a design with the wrong priority keeps port B's word, and a same-edge read and write of one address, where a write-first memory shows the new word one cycle early. It drives host and butterfly writes in modes that do not own them and unloads under an irregular ready pattern. A leaking write then shows up as a corrupted word, and a design that advanced on a stalled cycle skips or repeats an address in the drained sequence.

// File: rtl/fft_ram_pkg.sv
package fft_ram_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    MODE_LOAD  = 2'b00,
    MODE_CALC  = 2'b01,
    MODE_DRAIN = 2'b10,
    MODE_IDLE  = 2'b11
  } ram_mode_e;

  localparam int unsigned PART_RE = 0;
  localparam int unsigned PART_IM = 1;
  localparam int unsigned NPARTS  = 2;
endpackage

// File: rtl/addr_reverse.sv
module addr_reverse #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] idx,
  output logic [W-1:0] rev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rev[i] = idx[W-1-i];
  end
endmodule

// File: rtl/word_bank_2w2r.sv
module word_bank_2w2r #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] qa,
  output logic [DW-1:0] qb
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Reads see the contents from before this edge's writes.
  always_ff @(posedge clk) begin
    if (ra_en) qa <= store[ra_addr];
    if (rb_en) qb <= store[rb_addr];
  end

  // Port B is scheduled first, so port A's update lands last on a clash.
  always_ff @(posedge clk) begin
    if (wb_en) store[wb_addr] <= wb_data;
    if (wa_en) store[wa_addr] <= wa_data;
  end
endmodule

// File: rtl/host_sequencer.sv
module host_sequencer
  import fft_ram_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ram_mode_e     mode,
  input  logic          ld_valid,
  output logic          ld_ready,
  output logic          ld_fire,
  output logic [AW-1:0] ld_idx,
  input  logic          ul_ready,
  output logic          ul_valid,
  output logic          ul_rd_en,
  output logic [AW-1:0] ul_idx
);
  localparam int unsigned CW = AW + 1;

  logic [CW-1:0] ld_cnt;
  logic [CW-1:0] ul_cnt;

  assign ld_ready = (mode == MODE_LOAD) && !ld_cnt[AW];
  assign ld_fire  = ld_ready && ld_valid;
  assign ld_idx   = ld_cnt[AW-1:0];

  assign ul_rd_en = (mode == MODE_DRAIN) && !ul_cnt[AW] && (!ul_valid || ul_ready);
  assign ul_idx   = ul_cnt[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt <= '0;
    end else if (mode != MODE_LOAD) begin
      ld_cnt <= '0;
    end else if (ld_fire) begin
      ld_cnt <= ld_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_cnt   <= '0;
      ul_valid <= 1'b0;
    end else if (mode != MODE_DRAIN) begin
      ul_cnt   <= '0;
      ul_valid <= 1'b0;
    end else begin
      if (ul_rd_en) begin
        ul_cnt   <= ul_cnt + 1'b1;
        ul_valid <= 1'b1;
      end else if (ul_ready) begin
        ul_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cplx_sample_ram.sv
module cplx_sample_ram
  import fft_ram_pkg::*;
#(
  parameter int unsigned LOG2N = 10,
  parameter int unsigned DW    = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [DW-1:0]    ld_re,
  input  logic [DW-1:0]    ld_im,
  input  logic [LOG2N-1:0] bf_a_raddr,
  input  logic [LOG2N-1:0] bf_b_raddr,
  output logic [DW-1:0]    bf_a_re,
  output logic [DW-1:0]    bf_a_im,
  output logic [DW-1:0]    bf_b_re,
  output logic [DW-1:0]    bf_b_im,
  input  logic             bf_a_we,
  input  logic [LOG2N-1:0] bf_a_waddr,
  input  logic [DW-1:0]    bf_a_wre,
  input  logic [DW-1:0]    bf_a_wim,
  input  logic             bf_b_we,
  input  logic [LOG2N-1:0] bf_b_waddr,
  input  logic [DW-1:0]    bf_b_wre,
  input  logic [DW-1:0]    bf_b_wim,
  output logic             ul_valid,
  input  logic             ul_ready,
  output logic [DW-1:0]    ul_re,
  output logic [DW-1:0]    ul_im
);
  ram_mode_e mode_e;
  assign mode_e = ram_mode_e'(mode);

  logic is_load, is_calc;
  assign is_load = (mode_e == MODE_LOAD);
  assign is_calc = (mode_e == MODE_CALC);

  logic             ld_fire, ul_rd_en;
  logic [LOG2N-1:0] ld_idx, ld_addr, ul_idx;

  host_sequencer #(.AW(LOG2N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .ld_fire  (ld_fire),
    .ld_idx   (ld_idx),
    .ul_ready (ul_ready),
    .ul_valid (ul_valid),
    .ul_rd_en (ul_rd_en),
    .ul_idx   (ul_idx)
  );

  addr_reverse #(.W(LOG2N)) u_rev (
    .idx (ld_idx),
    .rev (ld_addr)
  );

  // Port steering: load owns write A, unload owns read A, compute owns all four.
  logic                     wa_en, wb_en, ra_en, rb_en;
  logic [LOG2N-1:0]         wa_addr, ra_addr;
  logic [NPARTS-1:0][DW-1:0] wa_data, wb_data, qa, qb;

  assign wa_en   = is_load ? ld_fire : (is_calc && bf_a_we);
  assign wa_addr = is_load ? ld_addr : bf_a_waddr;
  assign wb_en   = is_calc && bf_b_we;
  assign ra_en   = is_calc || ul_rd_en;
  assign ra_addr = is_calc ? bf_a_raddr : ul_idx;
  assign rb_en   = is_calc;

  assign wa_data[PART_RE] = is_load ? ld_re : bf_a_wre;
  assign wa_data[PART_IM] = is_load ? ld_im : bf_a_wim;
  assign wb_data[PART_RE] = bf_b_wre;
  assign wb_data[PART_IM] = bf_b_wim;

  for (genvar p = 0; p < NPARTS; p++) begin : g_part
    word_bank_2w2r #(.AW(LOG2N), .DW(DW)) u_bank (
      .clk     (clk),
      .wa_en   (wa_en),
      .wa_addr (wa_addr),
      .wa_data (wa_data[p]),
      .wb_en   (wb_en),
      .wb_addr (bf_b_waddr),
      .wb_data (wb_data[p]),
      .ra_en   (ra_en),
      .ra_addr (ra_addr),
      .rb_en   (rb_en),
      .rb_addr (bf_b_raddr),
      .qa      (qa[p]),
      .qb      (qb[p])
    );
  end

  assign bf_a_re = qa[PART_RE];
  assign bf_a_im = qa[PART_IM];
  assign bf_b_re = qb[PART_RE];
  assign bf_b_im = qb[PART_IM];
  assign ul_re   = qa[PART_RE];
  assign ul_im   = qa[PART_IM];
endmodule

// File: rtl/cplx_sample_ram_chk.sv
module cplx_sample_ram_chk #(
  parameter int unsigned LOG2N = 10,
  parameter int unsigned DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          ul_valid,
  input logic          ul_ready,
  input logic [DW-1:0] ul_re,
  input logic [DW-1:0] ul_im
);
  localparam int unsigned N = 1 << LOG2N;

  logic [LOG2N:0] taken;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    taken <= '0;
    else if (mode != 2'b00)        taken <= '0;
    else if (ld_valid && ld_ready) taken <= taken + 1'b1;
  end

  a_r1_ready_only_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (mode == 2'b00));

  a_r2_no_load_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (taken == N[LOG2N:0]) |-> !ld_ready);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_valid && !ul_ready && mode == 2'b10) |=>
      (ul_valid && $stable(ul_re) && $stable(ul_im)));

  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |=> !ul_valid);
endmodule

bind cplx_sample_ram cplx_sample_ram_chk #(.LOG2N(LOG2N), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .ld_valid (ld_valid),
  .ld_ready (ld_ready),
  .ul_valid (ul_valid),
  .ul_ready (ul_ready),
  .ul_re    (ul_re),
  .ul_im    (ul_im)
);

// File: tb/tb_cplx_sample_ram.sv
module tb_cplx_sample_ram;
  localparam int unsigned LOG2N = 4;
  localparam int unsigned N     = 1 << LOG2N;
  localparam int unsigned DW    = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [1:0]       mode;
  logic             ld_valid, ld_ready;
  logic [DW-1:0]    ld_re, ld_im;
  logic [LOG2N-1:0] bf_a_raddr, bf_b_raddr, bf_a_waddr, bf_b_waddr;
  logic [DW-1:0]    bf_a_re, bf_a_im, bf_b_re, bf_b_im;
  logic             bf_a_we, bf_b_we;
  logic [DW-1:0]    bf_a_wre, bf_a_wim, bf_b_wre, bf_b_wim;
  logic             ul_valid, ul_ready;
  logic [DW-1:0]    ul_re, ul_im;

  cplx_sample_ram #(.LOG2N(LOG2N), .DW(DW)) dut (.*);

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] m_re [N];
  logic [DW-1:0] m_im [N];
  logic [2*DW-1:0] expq [$];
  logic mon_on = 1'b0;
  int   mon_cyc = 0;
  logic done = 1'b0;

  function automatic logic [LOG2N-1:0] brev(input int unsigned k);
    logic [LOG2N-1:0] r;
    for (int b = 0; b < LOG2N; b++) r[b] = k[LOG2N-1-b];
    return r;
  endfunction

  task automatic chk(input string req, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: drives an irregular ready and pops the scoreboard on each transfer.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        mon_cyc++;
        ul_ready = (mon_cyc % 3) != 1;
        if (ul_valid && ul_ready) begin
          if (expq.size() == 0) begin
            chk("R8 extra word", {ul_re, ul_im}, '0);
          end else begin
            chk("R8 drain order", {ul_re, ul_im}, expq.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; ld_valid = 0; ld_re = '0; ld_im = '0;
    bf_a_raddr = '0; bf_b_raddr = '0; bf_a_we = 0; bf_b_we = 0;
    bf_a_waddr = '0; bf_b_waddr = '0; bf_a_wre = '0; bf_a_wim = '0;
    bf_b_wre = '0; bf_b_wim = '0; ul_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset valid", {63'd0, ul_valid}, 64'd0);
    chk("R1 ready in load", {63'd0, ld_ready}, 64'd1);

    // R2: load with gaps; model stores sample k at reversed index.
    for (int k = 0; k < N; k++) begin
      if (k % 3 == 2) begin
        ld_valid = 0;
        @(negedge clk);
      end
      ld_valid = 1; ld_re = 32'h1000_0000 + k; ld_im = 32'h2000_0000 + k;
      m_re[brev(k)] = ld_re; m_im[brev(k)] = ld_im;
      @(negedge clk);
    end
    ld_valid = 0;
    chk("R1 ready low when full", {63'd0, ld_ready}, 64'd0);

    // R3: dual reads one half-array apart.
    mode = 2'b01;
    for (int i = 0; i < N/2; i++) begin
      bf_a_raddr = i; bf_b_raddr = i + N/2;
      @(negedge clk);
      chk("R2 R3 port A", {bf_a_re, bf_a_im}, {m_re[i], m_im[i]});
      chk("R3 port B", {bf_b_re, bf_b_im}, {m_re[i+N/2], m_im[i+N/2]});
    end

    // R7: host pushes in compute mode are refused and ignored.
    ld_valid = 1; ld_re = 32'hDEAD_0000; ld_im = 32'hDEAD_0001;
    @(negedge clk);
    chk("R7 ready low in compute", {63'd0, ld_ready}, 64'd0);
    ld_valid = 0;

    // R4: two writes on one edge.
    bf_a_we = 1; bf_a_waddr = 2; bf_a_wre = 32'hA2; bf_a_wim = 32'hA3;
    bf_b_we = 1; bf_b_waddr = 3; bf_b_wre = 32'hB2; bf_b_wim = 32'hB3;
    m_re[2] = 32'hA2; m_im[2] = 32'hA3; m_re[3] = 32'hB2; m_im[3] = 32'hB3;
    @(negedge clk);
    bf_a_we = 0; bf_b_we = 0;
    bf_a_raddr = 2; bf_b_raddr = 3;
    @(negedge clk);
    chk("R4 write A seen", {bf_a_re, bf_a_im}, {m_re[2], m_im[2]});
    chk("R4 write B seen", {bf_b_re, bf_b_im}, {m_re[3], m_im[3]});

    // R5: both ports hit address 5.
    bf_a_we = 1; bf_a_waddr = 5; bf_a_wre = 32'hAAAA; bf_a_wim = 32'hAAAB;
    bf_b_we = 1; bf_b_waddr = 5; bf_b_wre = 32'hBBBB; bf_b_wim = 32'hBBBC;
    m_re[5] = 32'hAAAA; m_im[5] = 32'hAAAB;
    @(negedge clk);
    bf_a_we = 0; bf_b_we = 0; bf_b_raddr = 5;
    @(negedge clk);
    chk("R5 port A wins", {bf_b_re, bf_b_im}, {m_re[5], m_im[5]});

    // R6: read and write address 6 on one edge.
    bf_a_we = 1; bf_a_waddr = 6; bf_a_wre = 32'h6666; bf_a_wim = 32'h6667;
    bf_a_raddr = 6;
    @(negedge clk);
    chk("R6 old data", {bf_a_re, bf_a_im}, {m_re[6], m_im[6]});
    m_re[6] = 32'h6666; m_im[6] = 32'h6667;
    bf_a_we = 0;
    @(negedge clk);
    chk("R6 new data next", {bf_a_re, bf_a_im}, {m_re[6], m_im[6]});

    // R7: idle mode ignores everything.
    mode = 2'b11;
    ld_valid = 1; bf_a_we = 1; bf_a_waddr = 7; bf_a_wre = 32'hBAD; bf_a_wim = 32'hBAD;
    @(negedge clk);
    chk("R1 R7 ready low in idle", {63'd0, ld_ready}, 64'd0);
    ld_valid = 0;

    // Drain; a write attempt on the first unload cycle must be ignored.
    for (int i = 0; i < N; i++) expq.push_back({m_re[i], m_im[i]});
    mode = 2'b10; bf_a_waddr = 8; bf_b_we = 1; bf_b_waddr = 9;
    mon_on = 1'b1;
    @(negedge clk);
    bf_a_we = 0; bf_b_we = 0;
    for (int t = 0; t < 10*N && expq.size() != 0; t++) @(negedge clk);
    chk("R8 all words drained", 64'(expq.size()), 64'd0);
    mon_on = 1'b0; ul_ready = 0;
    mode = 2'b00;
    @(negedge clk);
    chk("R9 valid low after leaving", {63'd0, ul_valid}, 64'd0);
    chk("R2 load count restarted", {63'd0, ld_ready}, 64'd1);

    // R8 restart: re-enter unload, first word is address 0.
    mode = 2'b10; ul_ready = 0;
    @(negedge clk);
    chk("R8 restart at zero", {ul_valid, ul_re, ul_im}, {1'b1, m_re[0], m_im[0]});
    @(negedge clk);
    chk("R8 held while stalled", {ul_valid, ul_re, ul_im}, {1'b1, m_re[0], m_im[0]});

    done = 1'b1;
    finish_run();
  end
endmodule